// File: doc/BRIEF.md
# Link Header Credit Tracker

This block sits on the transmit side of a link and keeps account of the header-buffer credits that the far receiver has granted. Before a header packet goes out, the sender asks whether a credit is free. When one is, the block tells it which credit index the packet takes. Credit-return command words that arrive from the far side are decoded and checked against the credit the block expects next, so that a free credit is only counted again after its return has been validated.

The size of the pool follows the negotiated link mode. In two-lane high-rate mode seven credits (A to G, indices 0 to 6) are in play. In every other mode there are four (A to D, indices 0 to 3). A credit-return word is four bits wide. Bit 3 is the series bit and bits [2:0] are the credit index, where code 7 is reserved. Credits must be returned in strict order. The expected series bit starts at 0 and flips every time the expected index wraps from the last credit of the pool back to A. Header sequence numbering (0 to 15) is not touched by this block.

Top module: `link_hdr_credit_tracker`

## Requirements
- R1: After reset, with the mode input low, send_ok_o is 1, next_idx_o is 0, outstanding_o is 0 and err_o is 0.
- R2: With the mode input low, the pool holds 4 credits. outstanding_o never exceeds 4. send_ok_o is 0 while 4 credits are outstanding, and a send request in that state leaves outstanding_o unchanged.
- R3: With the mode input high, the pool holds 7 credits, with the same stall behaviour at 7 outstanding.
- R4: A send request while send_ok_o is 1 consumes the credit shown on next_idx_o. From the next cycle next_idx_o shows the following index, wrapping from the pool's last index (3 or 6) back to 0.
- R5: An accepted credit-return word lowers outstanding_o by one in the next cycle and advances the expected index.
- R6: A valid return word whose bits [2:0] equal 7 is rejected: err_o is 1 for the one following cycle, and outstanding_o is unchanged.
- R7: A valid return word whose index differs from the expected index is rejected with err_o and has no effect.
- R8: The expected series bit starts at 0 and toggles each time the expected index wraps past the last credit. A valid return word with the right index but the wrong bit 3 is rejected with err_o and has no effect.
- R9: A valid return word that arrives while outstanding_o is 0 is rejected with err_o, even if its index and series match.
- R10: In a cycle where the mode input differs from its previous value, send_ok_o is 0. Sends and returns in that cycle are ignored. From the next cycle the full pool of the new mode is free, next_idx_o and the expected index are 0, the expected series is 0, and err_o is 0.
- R11: A send and an accepted return in the same cycle leave outstanding_o unchanged, and both pointers advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_mode_i | input | 1 | 1 = two-lane high-rate mode (7 credits), 0 = 4 credits |
| hp_send_i | input | 1 | Sender wants to transmit a header packet this cycle |
| cmd_valid_i | input | 1 | cmd_word_i carries a credit-return word |
| cmd_word_i | input | 4 | Return word: bit 3 series, bits [2:0] credit index |
| send_ok_o | output | 1 | A credit is free; a send this cycle is taken |
| next_idx_o | output | 3 | Credit index the next sent packet uses |
| outstanding_o | output | 3 | Number of credits in use |
| err_o | output | 1 | One-cycle pulse after a rejected return word |

## Verification
send_ok_o is combinational on the current count and on the mode input. The bench therefore reads it one time unit after it drives the inputs, before the clock edge that acts on them. next_idx_o, outstanding_o and err_o are all registered and change one edge after the stimulus that causes them. The bench reads them at the falling edge that follows that rising edge, and compares them against a model it advances from the requirements in the same step. The sweeps offer all 16 return words at every expected position through several wraps in both modes. They also drive mode switches that carry a send and a return in the same cycle.

// File: rtl/lhct_pkg.sv
package lhct_pkg;
  localparam int IDX_W = 3;
  typedef logic [IDX_W-1:0] cidx_t;
  typedef struct packed {
    logic  series;
    cidx_t idx;
  } ccmd_t;
  localparam cidx_t IDX_RSV = '1;
endpackage

// File: rtl/credit_ptr.sv
module credit_ptr
  import lhct_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  adv_i,
  input  cidx_t last_i,
  output cidx_t idx_o,
  output logic  series_o
);
  cidx_t idx_q;
  logic  ser_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      ser_q <= 1'b0;
    end else if (clr_i) begin
      idx_q <= '0;
      ser_q <= 1'b0;
    end else if (adv_i) begin
      if (idx_q == last_i) begin
        idx_q <= '0;
        ser_q <= ~ser_q;
      end else begin
        idx_q <= idx_q + cidx_t'(1);
      end
    end
  end

  assign idx_o    = idx_q;
  assign series_o = ser_q;

  p_wrap_toggle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && adv_i && idx_o == last_i) |=> (idx_o == '0 && series_o != $past(series_o)));

  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && adv_i && idx_o != last_i) |=> (idx_o == $past(idx_o) + cidx_t'(1)));

  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (idx_o == '0 && !series_o));
endmodule

// File: rtl/credit_cmd_check.sv
module credit_cmd_check
  import lhct_pkg::*;
(
  input  logic  valid_i,
  input  ccmd_t cmd_i,
  input  cidx_t exp_idx_i,
  input  logic  exp_series_i,
  input  logic  empty_i,
  output logic  take_o,
  output logic  bad_o
);
  logic match;

  always_comb begin
    match  = (cmd_i.idx != IDX_RSV) && (cmd_i.idx == exp_idx_i)
             && (cmd_i.series == exp_series_i) && !empty_i;
    take_o = valid_i && match;
    bad_o  = valid_i && !match;
  end
endmodule

// File: rtl/link_hdr_credit_tracker.sv
module link_hdr_credit_tracker
  import lhct_pkg::*;
#(
  parameter int NARROW_CREDITS = 4,
  parameter int WIDE_CREDITS   = 7,
  localparam int CNT_W         = $clog2(WIDE_CREDITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wide_mode_i,
  input  logic             hp_send_i,
  input  logic             cmd_valid_i,
  input  logic [IDX_W:0]   cmd_word_i,
  output logic             send_ok_o,
  output logic [IDX_W-1:0] next_idx_o,
  output logic [CNT_W-1:0] outstanding_o,
  output logic             err_o
);
  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t POOL_N = cnt_t'(NARROW_CREDITS);
  localparam cnt_t POOL_W = cnt_t'(WIDE_CREDITS);

  logic  mode_q, mode_chg;
  cnt_t  pool, cnt_q, cnt_d;
  cidx_t last, tx_idx, ret_idx;
  logic  tx_ser, ret_ser;
  logic  send_take, ret_take, take, bad, err_q;
  ccmd_t cmd;

  assign cmd      = cmd_word_i;
  assign mode_chg = wide_mode_i ^ mode_q;
  assign pool     = mode_q ? POOL_W : POOL_N;
  assign last     = cidx_t'(pool - cnt_t'(1));

  assign send_ok_o = !mode_chg && (cnt_q < pool);
  assign send_take = hp_send_i && send_ok_o;
  assign ret_take  = take && !mode_chg;

  credit_ptr i_tx_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (mode_chg),
    .adv_i   (send_take),
    .last_i  (last),
    .idx_o   (tx_idx),
    .series_o(tx_ser)
  );

  credit_ptr i_ret_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (mode_chg),
    .adv_i   (ret_take),
    .last_i  (last),
    .idx_o   (ret_idx),
    .series_o(ret_ser)
  );

  credit_cmd_check i_cmd_check (
    .valid_i     (cmd_valid_i),
    .cmd_i       (cmd),
    .exp_idx_i   (ret_idx),
    .exp_series_i(ret_ser),
    .empty_i     (cnt_q == '0),
    .take_o      (take),
    .bad_o       (bad)
  );

  always_comb begin
    unique case ({send_take, ret_take})
      2'b10:   cnt_d = cnt_q + cnt_t'(1);
      2'b01:   cnt_d = cnt_q - cnt_t'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      mode_q <= wide_mode_i;
      cnt_q  <= mode_chg ? '0 : cnt_d;
      err_q  <= bad && !mode_chg;
    end
  end

  assign next_idx_o    = tx_idx;
  assign outstanding_o = cnt_q;
  assign err_o         = err_q;

  p_cnt_in_pool_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= pool);

  p_stall_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hp_send_i && !mode_chg && cnt_q == pool && !ret_take) |=> (cnt_q == $past(cnt_q)));

  p_ret_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_take && !send_take) |=> (cnt_q == $past(cnt_q) - cnt_t'(1)));

  p_rsv_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_word_i[IDX_W-1:0] == IDX_RSV && !mode_chg) |=> err_o);

  p_mode_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> (cnt_q == '0 && next_idx_o == '0 && !err_o));

  p_both_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_take && ret_take) |=> $stable(cnt_q));
endmodule

// File: tb/test_link_hdr_credit_tracker.sv
module test_link_hdr_credit_tracker;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wide_mode_i = 1'b0;
  logic       hp_send_i = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [3:0] cmd_word_i = '0;
  logic       send_ok_o;
  logic [2:0] next_idx_o;
  logic [2:0] outstanding_o;
  logic       err_o;

  int total = 0, bad = 0;
  bit done = 0;
  int m_out = 0, m_tx = 0, m_ret = 0, m_ser = 0, m_mode = 0;

  always #4 clk = ~clk;

  link_hdr_credit_tracker i_link_hdr_credit_tracker (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .wide_mode_i  (wide_mode_i),
    .hp_send_i    (hp_send_i),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_word_i   (cmd_word_i),
    .send_ok_o    (send_ok_o),
    .next_idx_o   (next_idx_o),
    .outstanding_o(outstanding_o),
    .err_o        (err_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_word();
    return (m_ser << 3) | m_ret;
  endfunction

  // drive at falling edge, model and check around the next rising edge
  task automatic cyc(bit s, bit v, int w, bit wm);
    int pool, idx;
    bit chg, ok, acc, e;
    string tag_ok, tag_out, tag_err;
    hp_send_i = s; cmd_valid_i = v; cmd_word_i = 4'(w); wide_mode_i = wm;
    #1;
    chg  = (int'(wm) != m_mode);
    pool = m_mode ? 7 : 4;
    ok   = !chg && m_out < pool;
    tag_ok = chg ? "R10" : (m_mode ? "R3" : "R2");
    chk(tag_ok, "send_ok", int'(send_ok_o), int'(ok));
    idx = w & 7;
    acc = 0; e = 0; tag_err = "R5";
    if (chg) begin
      tag_err = "R10";
    end else if (v) begin
      if (idx == 7) begin e = 1; tag_err = "R6"; end
      else if (idx != m_ret) begin e = 1; tag_err = "R7"; end
      else if (((w >> 3) & 1) != m_ser) begin e = 1; tag_err = "R8"; end
      else if (m_out == 0) begin e = 1; tag_err = "R9"; end
      else acc = 1;
    end
    if (chg) begin
      m_out = 0; m_tx = 0; m_ret = 0; m_ser = 0; m_mode = int'(wm);
      tag_out = "R10";
    end else begin
      if (s && acc && ok) tag_out = "R11";
      else if (acc) tag_out = "R5";
      else if (s && !ok) tag_out = tag_ok;
      else tag_out = e ? tag_err : "R4";
      if (s && ok) begin
        m_out++;
        m_tx = (m_tx == pool - 1) ? 0 : m_tx + 1;
      end
      if (acc) begin
        m_out--;
        if (m_ret == pool - 1) begin m_ret = 0; m_ser ^= 1; end
        else m_ret++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(chg ? "R10" : "R4", "next_idx", int'(next_idx_o), m_tx);
    chk(tag_out, "outstanding", int'(outstanding_o), m_out);
    chk(tag_err, "err", int'(err_o), int'(e));
  endtask

  task automatic sweep(bit wm);
    for (int c = 0; c < 16; c++) cyc(0, 1, c, wm);
  endtask

  task automatic run_mode(bit wm);
    cyc(1, 1, exp_word(), wm); // switch cycle, both ignored (R10)
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, wm); // fill past the pool, R2/R3 stall
    for (int r = 0; r < 16; r++) begin
      cyc(1, 0, 0, wm);
      sweep(wm);
    end
    for (int i = 0; i < 3; i++) cyc(1, 1, exp_word(), wm); // R11
    for (int r = 0; r < 9; r++) sweep(wm); // drain to empty, R9 underflow
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, wm);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    #1;
    chk("R1", "send_ok", int'(send_ok_o), 1);
    chk("R1", "next_idx", int'(next_idx_o), 0);
    chk("R1", "outstanding", int'(outstanding_o), 0);
    chk("R1", "err", int'(err_o), 0);
    @(negedge clk);
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0);
    for (int r = 0; r < 12; r++) begin
      cyc(1, 0, 0, 0);
      sweep(0);
    end
    run_mode(1);
    run_mode(0);
    run_mode(1);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule